// File: doc/BRIEF.md
# APB Address-Decoding Fabric

This block joins a single APB4 requester to a fixed number of memory-mapped APB completers. In the setup phase it compares the request address against a table of regions. Each region has a base, a bound and an access policy, and the table is set by parameters. The comparison yields a one-hot completer select, and the fabric raises only that completer's PSEL. The enable, address, direction, protection, write data and byte strobes go to every completer unchanged on shared wires. The ready, read data and error flag going back to the requester come from the completer that was chosen.

A region is hit when `base <= address < bound`. When regions overlap, the lowest-numbered hit wins. Any transfer that hits no region goes to the lowest-numbered slot whose policy is "error". So does any transfer whose direction the hit region's policy forbids. With `ERR_LOCAL` set, that error slot is answered inside the fabric, so no real completer has to sit behind it. The route decoded in the setup phase is registered. The access-phase response is taken from that stored route.

Top module: `apb_addr_fabric`

## Requirements
- R1: While `req_psel_i` is high, the fabric raises `cpl_psel_o[k]` for the slot k whose region satisfies base <= `req_paddr_i` < bound and whose policy allows the direction. Both the base and the last address below the bound select slot k.
- R2: At no time is more than one bit of `cpl_psel_o` high.
- R3: `cpl_penable_o`, `cpl_paddr_o`, `cpl_pwrite_o`, `cpl_pprot_o`, `cpl_pwdata_o` and `cpl_pstrb_o` equal the corresponding requester inputs at all times and are shared by all completers.
- R4: During a transfer to a real completer, `req_pready_o`, `req_prdata_o` and `req_pslverr_o` follow that completer's `cpl_pready_i`, `cpl_prdata_i` slice and `cpl_pslverr_i`. Completer wait states therefore stretch the access phase.
- R5: Policies are encoded per slot in two bits: 2'b00 error, 2'b01 read-only, 2'b10 write-only, 2'b11 read-write. A write to a read-only region is steered to the error slot, and so is a read from a write-only region.
- R6: An address that lies in no region is steered to the lowest-numbered error slot.
- R7: With `ERR_LOCAL`=1, the error slot's `cpl_psel_o` bit stays low. Every transfer routed there completes in its first access cycle with `req_pready_o`=1, `req_pslverr_o`=1 and `req_prdata_o`=0.
- R8: While `req_psel_i` is low, including directly after reset, all `cpl_psel_o` bits are low, `req_pready_o`=1, `req_pslverr_o`=0 and `req_prdata_o`=0, whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock shared by all ports |
| rst_ni | input | 1 | Synchronous reset, active low |
| req_psel_i | input | 1 | Requester select |
| req_penable_i | input | 1 | Requester access phase |
| req_paddr_i | input | ADDR_W | Requester address |
| req_pwrite_i | input | 1 | 1 = write, 0 = read |
| req_pprot_i | input | 3 | Protection attributes |
| req_pwdata_i | input | DATA_W | Write data |
| req_pstrb_i | input | DATA_W/8 | Write byte strobes |
| req_pready_o | output | 1 | Ready returned to requester |
| req_prdata_o | output | DATA_W | Read data returned to requester |
| req_pslverr_o | output | 1 | Error flag returned to requester |
| cpl_psel_o | output | NUM_SLOTS | One select per completer slot |
| cpl_penable_o | output | 1 | Shared access phase |
| cpl_paddr_o | output | ADDR_W | Shared address |
| cpl_pwrite_o | output | 1 | Shared direction |
| cpl_pprot_o | output | 3 | Shared protection attributes |
| cpl_pwdata_o | output | DATA_W | Shared write data |
| cpl_pstrb_o | output | DATA_W/8 | Shared byte strobes |
| cpl_pready_i | input | NUM_SLOTS | Ready from each completer |
| cpl_prdata_i | input | NUM_SLOTS*DATA_W | Read data from each completer, slot k at bits k*DATA_W upward |
| cpl_pslverr_i | input | NUM_SLOTS | Error flag from each completer |

## Verification
The bench aims at both edges of each region: the base itself and the word just below the bound. A comparator with the wrong inequality would select the wrong completer or the error slot at exactly those addresses. It sends writes into the read-only region and reads into the write-only region; a fabric that ignores policy would select a real completer and return its data without an error. Unmapped and far-away addresses must get the internal error answer. Here the bench ties the error slot's external ready low and its data to a marker, so a fabric that wrongly muxes the external slot would hang or return the marker. Completer wait states and a completer error flag confirm that the response really comes from the selected port. Idle cycles with an in-map address catch a select that leaks out while the requester is not selecting.

// File: rtl/apb_fab_pkg.sv
package apb_fab_pkg;

  typedef enum logic [1:0] {
    POL_ERR = 2'b00,
    POL_RO  = 2'b01,
    POL_WO  = 2'b10,
    POL_RW  = 2'b11
  } policy_e;

  // R5: does a policy admit a transfer of the given direction
  function automatic logic policy_allows(input logic [1:0] pol, input logic is_write);
    case (pol)
      POL_RO:  return !is_write;
      POL_WO:  return is_write;
      POL_RW:  return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/apb_fab_decode.sv
module apb_fab_decode #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 2,
  parameter int ERR_SLOT  = 0,
  parameter logic [NUM_SLOTS*ADDR_W-1:0] SLOT_BASE  = '0,
  parameter logic [NUM_SLOTS*ADDR_W-1:0] SLOT_BOUND = '0,
  parameter logic [NUM_SLOTS*2-1:0]      SLOT_POL   = '0
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 write_i,
  output logic [IDX_W-1:0]     idx_o,
  output logic [NUM_SLOTS-1:0] onehot_o
);
  import apb_fab_pkg::*;

  logic [NUM_SLOTS-1:0] hit;

  // R1 R5: per-slot window compare, base inclusive, bound exclusive
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] BASE_K  = SLOT_BASE[k*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] BOUND_K = SLOT_BOUND[k*ADDR_W +: ADDR_W];
    localparam logic [1:0]        POL_K   = SLOT_POL[k*2 +: 2];
    assign hit[k] = (POL_K != POL_ERR) && (addr_i >= BASE_K) && (addr_i < BOUND_K)
                    && policy_allows(POL_K, write_i);
  end

  // R6: fall back to the error slot, lowest-numbered hit has priority
  always_comb begin
    idx_o = IDX_W'(ERR_SLOT);
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (hit[k]) idx_o = IDX_W'(k);
    end
  end

  always_comb begin
    onehot_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (idx_o == IDX_W'(k)) onehot_o[k] = 1'b1;
    end
  end

endmodule

// File: rtl/apb_fab_route.sv
module apb_fab_route #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 2,
  parameter int ERR_SLOT  = 0,
  parameter bit ERR_LOCAL = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        psel_i,
  input  logic                        penable_i,
  input  logic [IDX_W-1:0]            dec_idx_i,
  input  logic [NUM_SLOTS-1:0]        cpl_pready_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] cpl_prdata_i,
  input  logic [NUM_SLOTS-1:0]        cpl_pslverr_i,
  output logic                        pready_o,
  output logic [DATA_W-1:0]           prdata_o,
  output logic                        pslverr_o
);

  logic [IDX_W-1:0]  route_q;
  logic [IDX_W-1:0]  resp_idx;
  logic [DATA_W-1:0] rd_slot [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_rd
    assign rd_slot[k] = cpl_prdata_i[k*DATA_W +: DATA_W];
  end

  // route captured in the setup phase, held for the access phase
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                  route_q <= IDX_W'(ERR_SLOT);
    else if (psel_i && !penable_i) route_q <= dec_idx_i;
  end

  assign resp_idx = penable_i ? route_q : dec_idx_i;

  // R4 R7 R8: response selection
  always_comb begin
    pready_o  = 1'b1;
    prdata_o  = '0;
    pslverr_o = 1'b0;
    if (psel_i) begin
      if (ERR_LOCAL && (resp_idx == IDX_W'(ERR_SLOT))) begin
        pslverr_o = penable_i;
      end else begin
        pready_o  = cpl_pready_i[resp_idx];
        prdata_o  = rd_slot[resp_idx];
        pslverr_o = cpl_pslverr_i[resp_idx];
      end
    end
  end

endmodule

// File: rtl/apb_addr_fabric.sv
module apb_addr_fabric #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter bit ERR_LOCAL = 1'b1,
  parameter logic [NUM_SLOTS*ADDR_W-1:0] SLOT_BASE  =
    {32'h0000_0000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NUM_SLOTS*ADDR_W-1:0] SLOT_BOUND =
    {32'h0000_0000, 32'h0000_3000, 32'h0000_2000, 32'h0000_1000},
  parameter logic [NUM_SLOTS*2-1:0]      SLOT_POL   =
    {2'b00, 2'b10, 2'b01, 2'b11}
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_psel_i,
  input  logic                        req_penable_i,
  input  logic [ADDR_W-1:0]           req_paddr_i,
  input  logic                        req_pwrite_i,
  input  logic [2:0]                  req_pprot_i,
  input  logic [DATA_W-1:0]           req_pwdata_i,
  input  logic [DATA_W/8-1:0]         req_pstrb_i,
  output logic                        req_pready_o,
  output logic [DATA_W-1:0]           req_prdata_o,
  output logic                        req_pslverr_o,
  output logic [NUM_SLOTS-1:0]        cpl_psel_o,
  output logic                        cpl_penable_o,
  output logic [ADDR_W-1:0]           cpl_paddr_o,
  output logic                        cpl_pwrite_o,
  output logic [2:0]                  cpl_pprot_o,
  output logic [DATA_W-1:0]           cpl_pwdata_o,
  output logic [DATA_W/8-1:0]         cpl_pstrb_o,
  input  logic [NUM_SLOTS-1:0]        cpl_pready_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] cpl_prdata_i,
  input  logic [NUM_SLOTS-1:0]        cpl_pslverr_i
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  function automatic int first_err_slot(input logic [NUM_SLOTS*2-1:0] pol);
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (pol[k*2 +: 2] == 2'b00) first_err_slot = k;
    end
  endfunction

  localparam int ERR_SLOT = first_err_slot(SLOT_POL);

  logic [IDX_W-1:0]     dec_idx;
  logic [NUM_SLOTS-1:0] dec_onehot;

  apb_fab_decode #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .ERR_SLOT  (ERR_SLOT),
    .SLOT_BASE (SLOT_BASE),
    .SLOT_BOUND(SLOT_BOUND),
    .SLOT_POL  (SLOT_POL)
  ) u_decode (
    .addr_i  (req_paddr_i),
    .write_i (req_pwrite_i),
    .idx_o   (dec_idx),
    .onehot_o(dec_onehot)
  );

  apb_fab_route #(
    .NUM_SLOTS(NUM_SLOTS),
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .ERR_SLOT (ERR_SLOT),
    .ERR_LOCAL(ERR_LOCAL)
  ) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .psel_i       (req_psel_i),
    .penable_i    (req_penable_i),
    .dec_idx_i    (dec_idx),
    .cpl_pready_i (cpl_pready_i),
    .cpl_prdata_i (cpl_prdata_i),
    .cpl_pslverr_i(cpl_pslverr_i),
    .pready_o     (req_pready_o),
    .prdata_o     (req_prdata_o),
    .pslverr_o    (req_pslverr_o)
  );

  // R1 R7 R8: per-slot select, local error slot never driven out
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_sel
    localparam bit MASKED = ERR_LOCAL && (k == ERR_SLOT);
    assign cpl_psel_o[k] = req_psel_i && dec_onehot[k] && !MASKED;
  end

  // R3: shared request wires
  assign cpl_penable_o = req_penable_i;
  assign cpl_paddr_o   = req_paddr_i;
  assign cpl_pwrite_o  = req_pwrite_i;
  assign cpl_pprot_o   = req_pprot_i;
  assign cpl_pwdata_o  = req_pwdata_i;
  assign cpl_pstrb_o   = req_pstrb_i;

endmodule

// File: rtl/apb_addr_fabric_chk.sv
module apb_addr_fabric_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int DATA_W    = 32,
  parameter bit ERR_LOCAL = 1'b1
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_psel_i,
  input logic                 req_penable_i,
  input logic                 req_pready_o,
  input logic [DATA_W-1:0]    req_prdata_o,
  input logic                 req_pslverr_o,
  input logic [NUM_SLOTS-1:0] cpl_psel_o,
  input logic [NUM_SLOTS-1:0] cpl_pready_i
);

  a_r2_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cpl_psel_o));

  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_psel_i |-> (cpl_psel_o == '0) && req_pready_o && !req_pslverr_o);

  a_r1_sel_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cpl_psel_o) |-> req_psel_i);

  a_r4_wait_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_psel_i && req_penable_i && (|(cpl_psel_o & ~cpl_pready_i)) |-> !req_pready_o);

  a_r7_local_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ERR_LOCAL && req_psel_i && req_penable_i && (cpl_psel_o == '0)
    |-> req_pready_o && req_pslverr_o && (req_prdata_o == '0));

endmodule

bind apb_addr_fabric apb_addr_fabric_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .DATA_W   (DATA_W),
  .ERR_LOCAL(ERR_LOCAL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_psel_i   (req_psel_i),
  .req_penable_i(req_penable_i),
  .req_pready_o (req_pready_o),
  .req_prdata_o (req_prdata_o),
  .req_pslverr_o(req_pslverr_o),
  .cpl_psel_o   (cpl_psel_o),
  .cpl_pready_i (cpl_pready_i)
);

// File: tb/tb_apb_addr_fabric.sv
`timescale 1ns/1ps
module tb_apb_addr_fabric;
  localparam int S  = 4;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic            psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0]   paddr = '0;
  logic [2:0]      pprot = '0;
  logic [DW-1:0]   pwdata = '0;
  logic [DW/8-1:0] pstrb = '0;
  logic            pready, pslverr;
  logic [DW-1:0]   prdata;
  logic [S-1:0]    c_psel;
  logic            c_penable, c_pwrite;
  logic [AW-1:0]   c_paddr;
  logic [2:0]      c_pprot;
  logic [DW-1:0]   c_pwdata;
  logic [DW/8-1:0] c_pstrb;
  logic [S-1:0]    rdy_v  = 4'b0111;  // slot 3 external ready tied low
  logic [S-1:0]    serr_v = 4'b0000;
  logic [S*DW-1:0] c_prdata;

  always_comb begin
    for (int k = 0; k < S; k++)
      c_prdata[k*DW +: DW] = (k == 3) ? 32'hDEAD_BEEF : (32'hC0DE_0000 | k);
  end

  apb_addr_fabric dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_psel_i(psel), .req_penable_i(penable), .req_paddr_i(paddr),
    .req_pwrite_i(pwrite), .req_pprot_i(pprot), .req_pwdata_i(pwdata),
    .req_pstrb_i(pstrb), .req_pready_o(pready), .req_prdata_o(prdata),
    .req_pslverr_o(pslverr), .cpl_psel_o(c_psel), .cpl_penable_o(c_penable),
    .cpl_paddr_o(c_paddr), .cpl_pwrite_o(c_pwrite), .cpl_pprot_o(c_pprot),
    .cpl_pwdata_o(c_pwdata), .cpl_pstrb_o(c_pstrb), .cpl_pready_i(rdy_v),
    .cpl_prdata_i(c_prdata), .cpl_pslverr_i(serr_v)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one complete transfer; slot = expected real completer, err = expect error slot
  task automatic xfer(input logic [AW-1:0] a, input logic w, input int slot,
                      input logic err, input int waits, input logic serr_exp);
    logic [S-1:0]  exp_sel;
    logic [DW-1:0] exp_dat;
    exp_sel = err ? '0 : (S'(1) << slot);
    exp_dat = err ? '0 : (32'hC0DE_0000 | slot);
    @(posedge clk); #1;
    psel = 1; penable = 0; paddr = a; pwrite = w; pprot = 3'b010;
    pwdata = ~a; pstrb = w ? 4'b1010 : 4'b0000;
    @(negedge clk);
    chk("R1/R5/R6 setup select", 64'(c_psel), 64'(exp_sel));
    @(posedge clk); #1;
    penable = 1;
    if (!err && waits > 0) rdy_v[slot] = 1'b0;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (!err) chk("R4 wait state", 64'(pready), 64'h0);
      @(posedge clk); #1;
    end
    rdy_v = 4'b0111;
    @(negedge clk);
    chk("R2/R1 access select", 64'(c_psel), 64'(exp_sel));
    chk("R3 broadcast", {c_paddr, c_pwdata}, {a, ~a});
    chk("R3 broadcast ctl", 64'({c_penable, c_pwrite, c_pprot, c_pstrb}),
        64'({1'b1, w, 3'b010, (w ? 4'b1010 : 4'b0000)}));
    chk(err ? "R7 ready" : "R4 ready", 64'(pready), 64'h1);
    chk(err ? "R7 data" : "R4 data", 64'(prdata), 64'(exp_dat));
    chk(err ? "R7 error flag" : "R4 error flag", 64'(pslverr), 64'(err ? 1'b1 : serr_exp));
    @(posedge clk); #1;
    psel = 0; penable = 0;
  endtask

  // {addr, write, err, slot}
  localparam logic [35:0] VEC [10] = '{
    {32'h0000_0000, 1'b0, 1'b0, 2'd0},  // R1 base of slot0
    {32'h0000_0FFC, 1'b1, 1'b0, 2'd0},  // R1 below bound
    {32'h0000_1000, 1'b0, 1'b0, 2'd1},  // R1 bound of slot0 = base of slot1
    {32'h0000_1FFC, 1'b0, 1'b0, 2'd1},
    {32'h0000_1004, 1'b1, 1'b1, 2'd3},  // R5 write to read-only
    {32'h0000_2000, 1'b1, 1'b0, 2'd2},  // R1 write-only base
    {32'h0000_2FFC, 1'b0, 1'b1, 2'd3},  // R5 read from write-only
    {32'h0000_3000, 1'b0, 1'b1, 2'd3},  // R6 just past last bound
    {32'h8000_0000, 1'b1, 1'b1, 2'd3},  // R6 far unmapped
    {32'h0000_0800, 1'b1, 1'b0, 2'd0}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1;
    paddr = 32'h0000_1000;
    @(negedge clk);
    chk("R8 in reset select", 64'(c_psel), 64'h0);
    @(posedge clk); #1; rst_ni = 1;
    @(negedge clk);
    chk("R8 after reset ready", 64'({pready, pslverr}), 64'h2);
    chk("R8 after reset data", 64'(prdata), 64'h0);

    for (int v = 0; v < 10; v++) begin
      xfer(VEC[v][35:4], VEC[v][3], int'(VEC[v][1:0]), VEC[v][2], 0, 1'b0);
    end

    // R4: two wait states from slot0
    xfer(32'h0000_0010, 1'b0, 0, 1'b0, 2, 1'b0);
    // R4: completer error flag from slot1
    serr_v = 4'b0010;
    xfer(32'h0000_1010, 1'b0, 1, 1'b0, 0, 1'b1);
    serr_v = 4'b0000;
    // R7: error transfer that would hang if external slot were used
    xfer(32'h0000_1100, 1'b1, 3, 1'b1, 0, 1'b0);

    // R8: idle with in-map address
    @(posedge clk); #1;
    psel = 0; penable = 1; paddr = 32'h0000_2004; pwrite = 1;
    @(negedge clk);
    chk("R8 idle select", 64'(c_psel), 64'h0);
    chk("R8 idle response", 64'({pready, pslverr, prdata}), {31'h0, 1'b1, 1'b0, 32'h0});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule